// File: doc/BRIEF.md
# Memory Traffic Generator Control Register File

This block is the software-visible settings and progress register file for a memory traffic generator that has an independent read channel and write channel. A host writes each channel's start address, a requested transfer count and a control word. The block then presents these settings as plain outputs to the channel sequencers: the enable bit, the area size code, the transfer size code, the aligned base address and the requested count.

The sequencers send back a one-cycle pulse for each finished transfer. The read data checker sends back a one-cycle pulse for each error it detects. The block keeps saturating tallies of these pulses. A count register has two roles. A write to it sets the requested count, and a requested count of zero tells the sequencer to run without stopping. A read of it returns the transfers finished since the previous read of that register, and the read also clears that tally.

The bus is a single-cycle register port. Read data is combinational while a read is selected, and any clear caused by the read takes effect on the clock edge that ends the access.

Top module: `trafgen_csr`

## Requirements
- R1: After reset, every register reads as zero and both channels present enable low, base zero, requested count zero and size codes zero.
- R2: The address registers sit at byte offsets 0x00 (read channel) and 0x10 (write channel). The low ALIGN_BITS bits of a written address are dropped, so that field reads back as zero and is presented as zero on the base output. The upper bits are held until the next write.
- R3: A write to a count register sets the requested count output to the written 32-bit value, zero included. The read channel uses offset 0x04 and the write channel uses 0x14. The output holds until the next write to that register.
- R4: A read of a count register returns, zero-extended, the number of progress pulses from that channel since the previous read of the same register, and the read clears the tally.
- R5: When a clearing read and an increment pulse fall in the same cycle, the tally after that edge is one.
- R6: A read of the error register at offset 0x08 returns the number of cycles with the error pulse high since its previous read, and the read clears the tally.
- R7: The write-error register at offset 0x18 always reads zero, and writes to it change no register or output.
- R8: The control words sit at offsets 0x0C (read channel) and 0x1C (write channel). Bits [3:0] hold the area size code, bits [7:4] hold the transfer size code, and bit 31 is the enable (1 = run, 0 = stop). Bits [30:8] read as zero and are not stored.
- R9: Every tally saturates at all ones (2^TALLY_W - 1) and does not wrap.
- R10: An access whose byte address has bits [1:0] nonzero is ignored: it reads zero, writes nothing and clears nothing.
- R11: A write to a count register leaves that channel's progress tally unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid while a read is selected |
| rdDone | input | 1 | Read channel finished one transfer |
| wrDone | input | 1 | Write channel finished one transfer |
| rdErr | input | 1 | Read checker found an error |
| rdEnable | output | 1 | Read channel run enable |
| rdTargetSize | output | 4 | Read channel area size code |
| rdXferSize | output | 4 | Read channel transfer size code |
| rdBase | output | 32 | Read channel aligned base address |
| rdCount | output | 32 | Read channel requested count (0 = non-stop) |
| wrEnable | output | 1 | Write channel run enable |
| wrTargetSize | output | 4 | Write channel area size code |
| wrXferSize | output | 4 | Write channel transfer size code |
| wrBase | output | 32 | Write channel aligned base address |
| wrCount | output | 32 | Write channel requested count (0 = non-stop) |

## Verification
The bench builds the block with TALLY_W = 4 and ALIGN_BITS left at 6. With a 4-bit tally, a few dozen pulses without a read drive the progress and error tallies into saturation, so the clamp at 15 can be observed through normal register reads. The same short run also covers the case where a clearing read coincides with an increment. The 6-bit alignment matches the required address masking, and random write data with the low bits set exercises that masking.

// File: rtl/trafgen_csr_pkg.sv
package trafgen_csr_pkg;

  localparam int REG_W  = 32;
  localparam int BUS_AW = 5;

  typedef enum logic [2:0] {
    IDX_RADDR = 3'd0,
    IDX_RCNT  = 3'd1,
    IDX_RERR  = 3'd2,
    IDX_RCTL  = 3'd3,
    IDX_WADDR = 3'd4,
    IDX_WCNT  = 3'd5,
    IDX_WERR  = 3'd6,
    IDX_WCTL  = 3'd7
  } regIdx_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic readHit;
    logic rdAddrWe;
    logic rdCntWe;
    logic rdCtlWe;
    logic wrAddrWe;
    logic wrCntWe;
    logic wrCtlWe;
    logic rdCntRe;
    logic rdErrRe;
    logic wrCntRe;
  } strobe_t;

  typedef struct packed {
    logic       enable;
    logic [3:0] xfer;
    logic [3:0] target;
  } chanCtl_t;

endpackage

// File: rtl/trafgen_csr_ctrl.sv
module trafgen_csr_ctrl
  import trafgen_csr_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [BUS_AW-1:0] busAddr,
  output strobe_t           strobes,
  output regIdx_e           readIdx
);

  logic    aligned;
  logic    wrHit;
  logic    rdHit;
  regIdx_e idx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign idx     = regIdx_e'(busAddr[4:2]);
  assign wrHit   = busSel && busWrite && aligned;
  assign rdHit   = busSel && !busWrite && aligned;
  assign readIdx = idx;

  always_comb begin
    strobes          = '0;
    strobes.readHit  = rdHit;
    strobes.rdAddrWe = wrHit && (idx == IDX_RADDR);
    strobes.rdCntWe  = wrHit && (idx == IDX_RCNT);
    strobes.rdCtlWe  = wrHit && (idx == IDX_RCTL);
    strobes.wrAddrWe = wrHit && (idx == IDX_WADDR);
    strobes.wrCntWe  = wrHit && (idx == IDX_WCNT);
    strobes.wrCtlWe  = wrHit && (idx == IDX_WCTL);
    strobes.rdCntRe  = rdHit && (idx == IDX_RCNT);
    strobes.rdErrRe  = rdHit && (idx == IDX_RERR);
    strobes.wrCntRe  = rdHit && (idx == IDX_WCNT);
  end

endmodule

// File: rtl/trafgen_csr_tally.sv
module trafgen_csr_tally #(
  parameter int TALLY_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               incr,
  input  logic               clear,
  output logic [TALLY_W-1:0] value
);

  localparam logic [TALLY_W-1:0] MAX_VAL = '1;
  localparam logic [TALLY_W-1:0] ONE_VAL = TALLY_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= '0;
    end else if (clear) begin
      value <= incr ? ONE_VAL : '0;
    end else if (incr && (value != MAX_VAL)) begin
      value <= value + ONE_VAL;
    end
  end

endmodule

// File: rtl/trafgen_csr_data.sv
module trafgen_csr_data
  import trafgen_csr_pkg::*;
#(
  parameter int TALLY_W    = 32,
  parameter int ALIGN_BITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  regIdx_e          readIdx,
  input  logic [REG_W-1:0] busWrData,
  output logic [REG_W-1:0] busRdData,
  input  logic             rdDone,
  input  logic             wrDone,
  input  logic             rdErr,
  output chanCtl_t         rdCtl,
  output chanCtl_t         wrCtl,
  output logic [REG_W-1:0] rdBase,
  output logic [REG_W-1:0] wrBase,
  output logic [REG_W-1:0] rdCount,
  output logic [REG_W-1:0] wrCount
);

  localparam int ADDR_KEEP = REG_W - ALIGN_BITS;
  localparam int NUM_TALLY = 3;
  localparam int T_RCNT    = 0;
  localparam int T_WCNT    = 1;
  localparam int T_RERR    = 2;

  logic [ADDR_KEEP-1:0] rdAddrQ;
  logic [ADDR_KEEP-1:0] wrAddrQ;
  logic [REG_W-1:0]     rdCntQ;
  logic [REG_W-1:0]     wrCntQ;
  chanCtl_t             rdCtlQ;
  chanCtl_t             wrCtlQ;
  chanCtl_t             ctlIn;

  logic [NUM_TALLY-1:0] tallyInc;
  logic [NUM_TALLY-1:0] tallyClr;
  logic [TALLY_W-1:0]   tallyVal [NUM_TALLY];

  // Bits of the write word that are never stored
  logic unusedWrBits;
  assign unusedWrBits = ^{busWrData[ALIGN_BITS-1:0], busWrData[30:8]};

  assign ctlIn.enable = busWrData[31];
  assign ctlIn.xfer   = busWrData[7:4];
  assign ctlIn.target = busWrData[3:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddrQ <= '0;
      wrAddrQ <= '0;
      rdCntQ  <= '0;
      wrCntQ  <= '0;
      rdCtlQ  <= '0;
      wrCtlQ  <= '0;
    end else begin
      if (strobes.rdAddrWe) rdAddrQ <= busWrData[REG_W-1:ALIGN_BITS];
      if (strobes.wrAddrWe) wrAddrQ <= busWrData[REG_W-1:ALIGN_BITS];
      if (strobes.rdCntWe)  rdCntQ  <= busWrData;
      if (strobes.wrCntWe)  wrCntQ  <= busWrData;
      if (strobes.rdCtlWe)  rdCtlQ  <= ctlIn;
      if (strobes.wrCtlWe)  wrCtlQ  <= ctlIn;
    end
  end

  assign tallyInc[T_RCNT] = rdDone;
  assign tallyInc[T_WCNT] = wrDone;
  assign tallyInc[T_RERR] = rdErr;
  assign tallyClr[T_RCNT] = strobes.rdCntRe;
  assign tallyClr[T_WCNT] = strobes.wrCntRe;
  assign tallyClr[T_RERR] = strobes.rdErrRe;

  for (genvar g = 0; g < NUM_TALLY; g++) begin : gTally
    trafgen_csr_tally #(.TALLY_W(TALLY_W)) i_tally (
      .clk   (clk),
      .rstN  (rstN),
      .incr  (tallyInc[g]),
      .clear (tallyClr[g]),
      .value (tallyVal[g])
    );
  end

  function automatic logic [REG_W-1:0] packCtl(input chanCtl_t c);
    logic [REG_W-1:0] w;
    w       = '0;
    w[31]   = c.enable;
    w[7:4]  = c.xfer;
    w[3:0]  = c.target;
    return w;
  endfunction

  always_comb begin
    busRdData = '0;
    if (strobes.readHit) begin
      unique case (readIdx)
        IDX_RADDR: busRdData = {rdAddrQ, {ALIGN_BITS{1'b0}}};
        IDX_RCNT:  busRdData = REG_W'(tallyVal[T_RCNT]);
        IDX_RERR:  busRdData = REG_W'(tallyVal[T_RERR]);
        IDX_RCTL:  busRdData = packCtl(rdCtlQ);
        IDX_WADDR: busRdData = {wrAddrQ, {ALIGN_BITS{1'b0}}};
        IDX_WCNT:  busRdData = REG_W'(tallyVal[T_WCNT]);
        IDX_WERR:  busRdData = '0;
        IDX_WCTL:  busRdData = packCtl(wrCtlQ);
        default:   busRdData = '0;
      endcase
    end
  end

  assign rdCtl   = rdCtlQ;
  assign wrCtl   = wrCtlQ;
  assign rdBase  = {rdAddrQ, {ALIGN_BITS{1'b0}}};
  assign wrBase  = {wrAddrQ, {ALIGN_BITS{1'b0}}};
  assign rdCount = rdCntQ;
  assign wrCount = wrCntQ;

endmodule

// File: rtl/trafgen_csr.sv
module trafgen_csr
  import trafgen_csr_pkg::*;
#(
  parameter int TALLY_W    = 32,
  parameter int ALIGN_BITS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        rdDone,
  input  logic        wrDone,
  input  logic        rdErr,
  output logic        rdEnable,
  output logic [3:0]  rdTargetSize,
  output logic [3:0]  rdXferSize,
  output logic [31:0] rdBase,
  output logic [31:0] rdCount,
  output logic        wrEnable,
  output logic [3:0]  wrTargetSize,
  output logic [3:0]  wrXferSize,
  output logic [31:0] wrBase,
  output logic [31:0] wrCount
);

  strobe_t  strobes;
  regIdx_e  readIdx;
  chanCtl_t rdCtl;
  chanCtl_t wrCtl;

  trafgen_csr_ctrl i_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes),
    .readIdx  (readIdx)
  );

  trafgen_csr_data #(
    .TALLY_W    (TALLY_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .readIdx   (readIdx),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .rdDone    (rdDone),
    .wrDone    (wrDone),
    .rdErr     (rdErr),
    .rdCtl     (rdCtl),
    .wrCtl     (wrCtl),
    .rdBase    (rdBase),
    .wrBase    (wrBase),
    .rdCount   (rdCount),
    .wrCount   (wrCount)
  );

  assign rdEnable     = rdCtl.enable;
  assign rdTargetSize = rdCtl.target;
  assign rdXferSize   = rdCtl.xfer;
  assign wrEnable     = wrCtl.enable;
  assign wrTargetSize = wrCtl.target;
  assign wrXferSize   = wrCtl.xfer;

endmodule

// File: rtl/trafgen_csr_chk.sv
module trafgen_csr_chk #(
  parameter int ALIGN_BITS = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWrite,
  input logic [4:0]  busAddr,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData,
  input logic        rdDone,
  input logic        wrDone,
  input logic        rdErr,
  input logic        rdEnable,
  input logic [3:0]  rdTargetSize,
  input logic [3:0]  rdXferSize,
  input logic [31:0] rdBase,
  input logic [31:0] rdCount,
  input logic        wrEnable,
  input logic [3:0]  wrTargetSize,
  input logic [3:0]  wrXferSize,
  input logic [31:0] wrBase,
  input logic [31:0] wrCount
);

  logic wrAt [8];
  logic rdAt [8];
  logic misRd;
  logic chkUnused;

  for (genvar g = 0; g < 8; g++) begin : gAt
    assign wrAt[g] = busSel && busWrite && (busAddr == 5'(g * 4));
    assign rdAt[g] = busSel && !busWrite && (busAddr == 5'(g * 4));
  end
  assign misRd = busSel && !busWrite && (busAddr[1:0] != 2'b00);
  assign chkUnused = ^{rdDone, wrDone, rdErr, wrCount[0], rdCount[0]};

  AST_RESET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!rdEnable && !wrEnable && rdBase == 32'd0 && wrBase == 32'd0)); // R1

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (rdBase[ALIGN_BITS-1:0] == '0) && (wrBase[ALIGN_BITS-1:0] == '0)); // R2

  AST_RBASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrAt[0] |=> $stable(rdBase)); // R2

  AST_RCOUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrAt[1] |=> $stable(rdCount)); // R3

  AST_WCOUNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrAt[5] |=> (wrCount == $past(busWrData))); // R3

  AST_WERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdAt[6] |-> (busRdData == 32'd0)); // R7

  AST_RCTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrAt[3] |=> $stable({rdEnable, rdTargetSize, rdXferSize})); // R8

  AST_WCTL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrAt[7] |=> (wrEnable == $past(busWrData[31]) && wrXferSize == $past(busWrData[7:4])
                 && wrTargetSize == $past(busWrData[3:0]))); // R8

  AST_CTL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAt[3] || rdAt[7]) |-> (busRdData[30:8] == 23'd0)); // R8

  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    misRd |-> (busRdData == 32'd0)); // R10

endmodule

bind trafgen_csr trafgen_csr_chk #(.ALIGN_BITS(ALIGN_BITS)) i_chk (.*);

// File: tb/test_trafgen_csr.sv
module test_trafgen_csr;

  localparam int TW = 4;
  localparam logic [31:0] TMAX = 32'((1 << TW) - 1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        rdDone = 1'b0, wrDone = 1'b0, rdErr = 1'b0;
  logic        rdEnable, wrEnable;
  logic [3:0]  rdTargetSize, rdXferSize, wrTargetSize, wrXferSize;
  logic [31:0] rdBase, rdCount, wrBase, wrCount;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Bench model
  logic [31:0] mAddr [2];
  logic [31:0] mCnt  [2];
  logic [31:0] mCtl  [2];
  logic [31:0] mTally [3]; // 0 read progress, 1 write progress, 2 read errors

  always #2 clk = ~clk;

  trafgen_csr #(.TALLY_W(TW), .ALIGN_BITS(6)) i_trafgen_csr (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .rdDone(rdDone), .wrDone(wrDone),
    .rdErr(rdErr), .rdEnable(rdEnable), .rdTargetSize(rdTargetSize), .rdXferSize(rdXferSize),
    .rdBase(rdBase), .rdCount(rdCount), .wrEnable(wrEnable), .wrTargetSize(wrTargetSize),
    .wrXferSize(wrXferSize), .wrBase(wrBase), .wrCount(wrCount)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] satInc(input logic [31:0] v);
    return (v == TMAX) ? v : v + 32'd1;
  endfunction

  function automatic logic [31:0] expRead(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'd0;
    case (a[4:2])
      3'd0: return mAddr[0];
      3'd1: return mTally[0];
      3'd2: return mTally[2];
      3'd3: return mCtl[0];
      3'd4: return mAddr[1];
      3'd5: return mTally[1];
      3'd7: return mCtl[1];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqOf(input logic [4:0] a);
    if (a[1:0] != 2'b00) return "R10";
    case (a[4:2])
      3'd0, 3'd4: return "R2";
      3'd1, 3'd5: return "R4";
      3'd2:       return "R6";
      3'd6:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic checkOutputs();
    check("R8", "rd ctl outputs", {rdEnable, 23'd0, rdXferSize, rdTargetSize}, mCtl[0]);
    check("R8", "wr ctl outputs", {wrEnable, 23'd0, wrXferSize, wrTargetSize}, mCtl[1]);
    check("R2", "rdBase", rdBase, mAddr[0]);
    check("R2", "wrBase", wrBase, mAddr[1]);
    check("R3", "rdCount", rdCount, mCnt[0]);
    check("R3", "wrCount", wrCount, mCnt[1]);
  endtask

  // One bus cycle with optional pulses; tag overrides the requirement of the read check
  task automatic step(input logic sel, input logic wr, input logic [4:0] a, input logic [31:0] wd,
                      input logic pr, input logic pw, input logic pe, input string tag);
    logic hit;
    logic [2:0] idx;
    logic [2:0] inc, clr;
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = a; busWrData = wd;
    rdDone = pr; wrDone = pw; rdErr = pe;
    #1;
    checkOutputs();
    if (sel && !wr) check((tag != "") ? tag : reqOf(a), "read data", busRdData, expRead(a));
    @(posedge clk);
    hit = sel && (a[1:0] == 2'b00);
    idx = a[4:2];
    if (hit && wr) begin
      case (idx)
        3'd0: mAddr[0] = wd & 32'hFFFF_FFC0;
        3'd1: mCnt[0]  = wd;
        3'd3: mCtl[0]  = wd & 32'h8000_00FF;
        3'd4: mAddr[1] = wd & 32'hFFFF_FFC0;
        3'd5: mCnt[1]  = wd;
        3'd7: mCtl[1]  = wd & 32'h8000_00FF;
        default: ;
      endcase
    end
    inc = {pe, pw, pr};
    clr = {hit && !wr && idx == 3'd2, hit && !wr && idx == 3'd5, hit && !wr && idx == 3'd1};
    for (int k = 0; k < 3; k++)
      mTally[k] = clr[k] ? {31'd0, inc[k]} : (inc[k] ? satInc(mTally[k]) : mTally[k]);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 1'b0, 1'b0, 1'b0, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin mAddr[k] = 0; mCnt[k] = 0; mCtl[k] = 0; end
    for (int k = 0; k < 3; k++) mTally[k] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOutputs(); // R1 outputs during reset
    rstN = 1'b1;
    for (int r = 0; r < 8; r++) rd(5'(r * 4), "R1");

    // R2 address masking, R10 offsets via each register
    wr(5'h00, 32'h1234_567F);
    wr(5'h10, 32'hFEDC_BA3F);
    rd(5'h00, "R2"); rd(5'h10, "R2");
    // R3 counts, including zero meaning non-stop
    wr(5'h04, 32'd0);
    wr(5'h14, 32'hDEAD_0001);
    wr(5'h04, 32'd77);
    // R8 control with reserved bits set
    wr(5'h0C, 32'hFFFF_FF5A);
    wr(5'h1C, 32'h7FFF_FF3C);
    rd(5'h0C, "R8"); rd(5'h1C, "R8");
    // R7 write-error writes ignored
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, "R7");
    // R10 misaligned write ignored, misaligned read zero and does not clear
    step(1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 1'b0, 1'b0, "");
    wr(5'h01, 32'hAAAA_AAAA);
    rd(5'h05, "R10");
    rd(5'h00, "R10");
    rd(5'h04, "R10");
    // R4 progress count and clear
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 5'd0, 32'd0, 1'b1, k[0], 1'b0, "");
    rd(5'h04, "R4"); rd(5'h04, "R4"); rd(5'h14, "R4");
    // R11 count write keeps tally
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 1'b0, "");
    wr(5'h14, 32'd9);
    rd(5'h14, "R11");
    // R6 one error per cycle
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 1'b1, "");
    rd(5'h08, "R6");
    // R9 saturation of all tallies
    for (int k = 0; k < 25; k++) step(1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 1'b1, 1'b1, "");
    rd(5'h04, "R9"); rd(5'h14, "R9"); rd(5'h08, "R9");
    // R5 clearing read coincides with increment
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 1'b0, 1'b1, "");
    step(1'b1, 1'b0, 5'h04, 32'd0, 1'b1, 1'b0, 1'b0, "R5");
    rd(5'h04, "R5");
    step(1'b1, 1'b0, 5'h08, 32'd0, 1'b0, 1'b0, 1'b1, "R5");
    rd(5'h08, "R5");

    // Random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [4:0] a;
      a = ($urandom % 8 == 0) ? 5'($urandom) : 5'(($urandom % 8) * 4);
      step(($urandom % 3) != 0, ($urandom % 2) == 1, a, $urandom,
           ($urandom % 2) == 1, ($urandom % 3) == 0, ($urandom % 4) == 0, "");
    end
    idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule